// File: doc/BRIEF.md
# Sampled Pin Glitch Filter

This block cleans up one asynchronous interrupt pin before any edge detection sees it. The raw level first crosses into the clock domain through a two-flop synchronizer. A free-running divider then issues a one-cycle sample strobe every P clocks, and the filtered output takes on a new level only when three samples in a row all show that level. Any pulse shorter than the reject bound is dropped. Any pulse at least as wide as the accept bound always gets through. Widths between the two bounds may or may not pass, depending on how the pulse lines up with the strobe.

One build of the block has a run-time period select. With `short_win` high the strobe interval is 16 clocks; with it low the interval is 64 clocks. The other builds are elaborated with a fixed interval: 8 clocks for the medium channel and 2 clocks for the fast one. In a fixed build `short_win` has no effect. Edge selection, interrupt latching and register access all sit outside this block.

Top module: `pin_glitch_filter`

## Requirements
- R1: After a clock edge with `rst_n` low, `level_out` is 0.
- R2: `level_out` changes only on a sample strobe, and only when three consecutive samples equal the new level. A sample that equals the current output clears the pending agreement count.
- R3: The sample interval P is 16 clocks when `short_win` is 1 and 64 clocks when it is 0 on the selectable build. On a fixed build P is the elaborated period and `short_win` has no effect.
- R4: Selectable build, `short_win` = 1: a high pulse narrower than 15 clocks never reaches `level_out`, and a pulse of 48 clocks or more always does.
- R5: Selectable build, `short_win` = 0: a pulse narrower than 63 clocks never passes, and a pulse of 192 clocks or more always passes.
- R6: Fixed medium build (P = 8): pulses under 7 clocks are rejected and pulses of 24 clocks or more pass.
- R7: Fixed fast build (P = 2): pulses under 2 clocks are rejected and pulses of 6 clocks or more pass.
- R8: Take edge k as the first rising clock edge at which a clean raw change is present. `level_out` follows the change no later than edge k + 3P + 1, which is 49, 193, 25 and 7 clocks for the four periods.
- R9: After `short_win` changes, a sample strobe under the new period arrives within 64 clocks, and from then on the new interval applies.
- R10: The raw pin passes through two flops before sampling, so `level_out` cannot follow a change earlier than edge k + 2P + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_raw | input | 1 | Asynchronous raw pin level |
| short_win | input | 1 | 1 = short sample period, 0 = long period (selectable build only) |
| level_out | output | 1 | Filtered pin level |

## Verification
The bench sweeps pulse widths just under the reject bound and exactly at the accept bound through every strobe phase. A filter that counted spans wrongly would let a short glitch through or lose a long pulse at some alignment. A high/low/high pattern gives two agreeing samples, then one disagreeing sample, then two agreeing samples again. This catches an agreement counter that is not cleared by the disagreeing sample, because such a counter would let the output rise. Latency is measured against both an upper and a lower bound, so a missing synchronizer stage or an extra one is exposed. Switching `short_win` in the middle of a count, followed by a width that only the short window accepts, catches a divider that never wraps or keeps the stale limit.

// File: rtl/pgf_pkg.sv
// Shared definitions for the sampled pin glitch filter.
package pgf_pkg;

    // Selects whether the sample period is fixed or run-time selectable.
    typedef enum logic {
        PERIOD_FIXED  = 1'b0,
        PERIOD_SELECT = 1'b1
    } period_mode_e;

    // Number of consecutive agreeing samples needed to move the output.
    localparam int unsigned DEF_AGREE = 3;

    // Counter width able to hold values 0 .. n-1, at least one bit.
    function automatic int unsigned width_for(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pgf_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes STAGES >= 2 and that d has no timing relation to clk.
module pgf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pgf_sample_timer.sv
// Free-running divider that issues a one-cycle sample strobe every
// P clocks. In selectable mode P is SHORT_DIV or LONG_DIV, chosen by
// short_win. In fixed mode P is LONG_DIV and short_win is ignored.
// The count is compared against the limit with ">=", so a switch to a
// smaller limit wraps on the next cycle and never runs off the end.
// Assumes 2 <= SHORT_DIV <= LONG_DIV.
module pgf_sample_timer
    import pgf_pkg::*;
#(
    parameter period_mode_e MODE      = PERIOD_SELECT,
    parameter int unsigned  SHORT_DIV = 16,
    parameter int unsigned  LONG_DIV  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic short_win,
    output logic tick
);

    localparam int unsigned    CW        = width_for(LONG_DIV);
    localparam logic [CW-1:0]  SHORT_LIM = CW'(SHORT_DIV - 1);
    localparam logic [CW-1:0]  LONG_LIM  = CW'(LONG_DIV - 1);

    logic [CW-1:0] div_q;
    logic [CW-1:0] limit;

    generate
        if (MODE == PERIOD_SELECT) begin : g_select
            // Pick the terminal count from the period-select input.
            assign limit = short_win ? SHORT_LIM : LONG_LIM;
        end else begin : g_fixed
            logic unused_sel;
            // Fixed build: the select input has no effect.
            assign unused_sel = short_win;
            assign limit      = LONG_LIM;
        end
    endgenerate

    // Strobe when the count reaches (or has passed) the terminal value.
    assign tick = (div_q >= limit);

    // Advance the divider, restarting after each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/pgf_vote.sv
// Consecutive-agreement filter. On each strobe the sample is compared
// with the current output. A differing sample adds one vote. When AGREE
// votes in a row have accumulated, the output takes the new level.
// A sample equal to the output clears the vote count.
// Assumes AGREE >= 2 and that sample is already synchronous.
module pgf_vote
    import pgf_pkg::*;
#(
    parameter int unsigned AGREE = DEF_AGREE,
    parameter int unsigned VW    = width_for(AGREE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          sample,
    output logic          level,
    output logic [VW-1:0] votes
);

    localparam logic [VW-1:0] LAST_VOTE = VW'(AGREE - 1);

    // Update the vote count and the filtered level on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
            votes <= '0;
        end else if (tick) begin
            if (sample == level) begin
                votes <= '0;
            end else if (votes == LAST_VOTE) begin
                level <= sample;
                votes <= '0;
            end else begin
                votes <= votes + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pin_glitch_filter.sv
// Top of the sampled pin glitch filter: a synchronizer, then a sample
// strobe divider, then a consecutive-agreement vote.
// Reject bound is about 2P+1 clocks and accept bound is 3P clocks,
// where P is the active sample period.
// Assumes a synchronous active-low reset and that short_win comes from
// the clk domain.
module pin_glitch_filter
    import pgf_pkg::*;
#(
    parameter period_mode_e MODE      = PERIOD_SELECT,
    parameter int unsigned  SHORT_DIV = 16,
    parameter int unsigned  LONG_DIV  = 64,
    parameter int unsigned  AGREE     = DEF_AGREE,
    parameter int unsigned  SYNC_LEN  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic short_win,
    output logic level_out
);

    localparam int unsigned VW = width_for(AGREE);

    logic          sync_lvl;
    logic          smp_tick;
    logic [VW-1:0] vote_cnt;

    pgf_sync #(
        .STAGES (SYNC_LEN)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (sync_lvl)
    );

    pgf_sample_timer #(
        .MODE      (MODE),
        .SHORT_DIV (SHORT_DIV),
        .LONG_DIV  (LONG_DIV)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .short_win (short_win),
        .tick      (smp_tick)
    );

    pgf_vote #(
        .AGREE (AGREE),
        .VW    (VW)
    ) u_vote (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (smp_tick),
        .sample (sync_lvl),
        .level  (level_out),
        .votes  (vote_cnt)
    );

endmodule

// File: rtl/pin_glitch_filter_chk.sv
// Assertion checker for pin_glitch_filter, attached with bind below.
// It watches the synchronized sample, the strobe and the vote count.
module pin_glitch_filter_chk
    import pgf_pkg::*;
#(
    parameter int unsigned LONG_DIV = 64,
    parameter int unsigned AGREE    = DEF_AGREE,
    parameter int unsigned VW       = width_for(AGREE)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pin_raw,
    input logic          sample,
    input logic          tick,
    input logic [VW-1:0] votes,
    input logic          level
);

    localparam int unsigned GW = width_for(LONG_DIV) + 1;

    logic [GW-1:0] gap_q;
    logic [1:0]    since_rst_q;

    // Count the cycles since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    gap_q <= '0;
        else if (tick) gap_q <= '0;
        else           gap_q <= gap_q + 1'b1;
    end

    // Count the first cycles out of reset, saturating at 2.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst_q <= '0;
        else if (since_rst_q != 2'd2) since_rst_q <= since_rst_q + 1'b1;
    end

    p_moves_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> $past(tick));

    p_moves_to_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> ($past(sample) == level));

    p_votes_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        votes < VW'(AGREE));

    p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q < GW'(LONG_DIV));

    p_sync_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd2) |-> (sample == $past(pin_raw, 2)));

endmodule

bind pin_glitch_filter pin_glitch_filter_chk #(
    .LONG_DIV (LONG_DIV),
    .AGREE    (AGREE),
    .VW       (VW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_raw (pin_raw),
    .sample  (sync_lvl),
    .tick    (smp_tick),
    .votes   (vote_cnt),
    .level   (level_out)
);

// File: tb/pin_glitch_filter_test.sv
// Bench for three builds of the filter: selectable 16/64, fixed 8 and
// fixed 2. A behavioural model is compared on every clock, and directed
// pulse, latency and select-change checks run on top of it.
module pin_glitch_filter_test;
    import pgf_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b1;
    logic pin_s = 1'b0, pin_m = 1'b0, pin_f = 1'b0;
    logic out_s, out_m, out_f;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   cmp_on = 1'b0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    pin_glitch_filter #(.MODE(PERIOD_SELECT), .SHORT_DIV(16), .LONG_DIV(64)) uut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_s), .short_win(sel), .level_out(out_s));
    pin_glitch_filter #(.MODE(PERIOD_FIXED), .SHORT_DIV(8), .LONG_DIV(8)) uut_med (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_m), .short_win(sel), .level_out(out_m));
    pin_glitch_filter #(.MODE(PERIOD_FIXED), .SHORT_DIV(2), .LONG_DIV(2)) uut_fast (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_f), .short_win(sel), .level_out(out_f));

    function automatic logic get_out(input int ch);
        return (ch == 0) ? out_s : (ch == 1) ? out_m : out_f;
    endfunction

    function automatic logic get_pin(input int ch);
        return (ch == 0) ? pin_s : (ch == 1) ? pin_m : pin_f;
    endfunction

    function automatic int period_of(input int ch);
        return (ch == 0) ? (sel ? 16 : 64) : (ch == 1) ? 8 : 2;
    endfunction

    task automatic set_pin(input int ch, input logic v);
        if (ch == 0) pin_s = v; else if (ch == 1) pin_m = v; else pin_f = v;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural reference: a delay queue per pin, a phase counter and a run count.
    bit dly[3][$];
    int phase[3];
    int run[3];
    bit mref[3];

    always @(posedge clk) begin
        for (int ch = 0; ch < 3; ch++) begin
            if (!rst_n) begin
                dly[ch] = '{1'b0, 1'b0};
                phase[ch] = 0; run[ch] = 0; mref[ch] = 1'b0;
            end else begin
                bit seen;
                seen = dly[ch][0];
                if (phase[ch] >= period_of(ch) - 1) begin
                    if (seen == mref[ch]) run[ch] = 0;
                    else begin
                        run[ch]++;
                        if (run[ch] == 3) begin mref[ch] = seen; run[ch] = 0; end
                    end
                    phase[ch] = 0;
                end else phase[ch]++;
                void'(dly[ch].pop_front());
                dly[ch].push_back(get_pin(ch));
            end
        end
    end

    // Compare every clock (R2 R10 behaviour, strobe timing R3).
    always @(negedge clk) begin
        if (cmp_on && !finished)
            for (int ch = 0; ch < 3; ch++)
                check(get_out(ch) == mref[ch], "R2 model compare", get_out(ch), mref[ch]);
    end

    // Apply one high pulse of w clocks and report whether the output rose.
    task automatic run_pulse(input int ch, input int w, output bit seen);
        int settle;
        settle = 4 * period_of(ch) + 6;
        seen = 1'b0;
        @(negedge clk); set_pin(ch, 1'b1);
        repeat (w) begin @(negedge clk); if (get_out(ch)) seen = 1'b1; end
        set_pin(ch, 1'b0);
        repeat (settle) begin @(negedge clk); if (get_out(ch)) seen = 1'b1; end
    endtask

    // Measure edges from the raw rise to the output rise, then return low.
    task automatic measure(input int ch, input string req);
        int n, p;
        p = period_of(ch);
        n = 0;
        @(negedge clk); set_pin(ch, 1'b1);
        while (n < 400) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (get_out(ch)) break;
        end
        check((n - 1) <= 3 * p + 1, req, n - 1, 3 * p + 1);
        check((n - 1) >= 2 * p + 2, "R10 min latency", n - 1, 2 * p + 2);
        set_pin(ch, 1'b0);
        repeat (4 * p + 6) @(negedge clk);
    endtask

    initial begin
        bit seen;
        repeat (4) @(negedge clk);
        // R1: reset state.
        check(out_s == 1'b0, "R1 reset sel", out_s, 0);
        check(out_m == 1'b0, "R1 reset med", out_m, 0);
        check(out_f == 1'b0, "R1 reset fast", out_f, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        repeat (3) @(negedge clk);

        // R4: short window, every phase.
        for (int off = 0; off < 16; off++) begin
            repeat (off) @(negedge clk);
            run_pulse(0, 14, seen); check(!seen, "R4 reject 14", seen, 0);
            repeat (off) @(negedge clk);
            run_pulse(0, 48, seen); check(seen, "R4 pass 48", seen, 1);
        end

        // R9: switch to long mid-count, then a 60-clock pulse must be dropped.
        repeat (5) @(negedge clk);
        sel = 1'b0;
        repeat (64) @(negedge clk);
        run_pulse(0, 60, seen); check(!seen, "R9 long after switch", seen, 0);

        // R5: long window at several phases.
        for (int k = 0; k < 3; k++) begin
            repeat (k * 23) @(negedge clk);
            run_pulse(0, 62, seen); check(!seen, "R5 reject 62", seen, 0);
            repeat (k * 19) @(negedge clk);
            run_pulse(0, 192, seen); check(seen, "R5 pass 192", seen, 1);
        end
        measure(0, "R8 latency long");

        // R9: switch back to short mid-count, then 48 must pass.
        repeat (30) @(negedge clk);
        sel = 1'b1;
        repeat (64) @(negedge clk);
        run_pulse(0, 48, seen); check(seen, "R9 short after switch", seen, 1);
        measure(0, "R8 latency short");

        // R6 / R3: medium fixed build, select toggled to show it has no effect.
        for (int off = 0; off < 8; off++) begin
            sel = off[0];
            repeat (off) @(negedge clk);
            run_pulse(1, 6, seen); check(!seen, "R6 reject 6", seen, 0);
            repeat (off) @(negedge clk);
            run_pulse(1, 24, seen); check(seen, "R6 pass 24", seen, 1);
        end
        measure(1, "R8 latency med");

        // R7: fast fixed build.
        for (int off = 0; off < 2; off++) begin
            repeat (off) @(negedge clk);
            run_pulse(2, 1, seen); check(!seen, "R7 reject 1", seen, 0);
            repeat (off) @(negedge clk);
            run_pulse(2, 6, seen); check(seen, "R7 pass 6", seen, 1);
        end
        measure(2, "R8 latency fast");

        // R2: two agreeing samples, one disagreeing, repeated, must not pass.
        for (int off = 0; off < 8; off++) begin
            seen = 1'b0;
            repeat (off) @(negedge clk);
            for (int rep = 0; rep < 3; rep++) begin
                pin_m = 1'b1;
                repeat (16) begin @(negedge clk); if (out_m) seen = 1'b1; end
                pin_m = 1'b0;
                repeat (8) begin @(negedge clk); if (out_m) seen = 1'b1; end
            end
            repeat (40) begin @(negedge clk); if (out_m) seen = 1'b1; end
            check(!seen, "R2 vote cleared", seen, 0);
        end

        // R1: reset in mid-pulse returns the output low.
        pin_f = 1'b1;
        repeat (12) @(negedge clk);
        check(out_f == 1'b1, "R7 level held", out_f, 1);
        cmp_on = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(out_f == 1'b0, "R1 reset clears", out_f, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule